// File: doc/BRIEF.md
# Prefetch Candidate Queue

This block sits between a prefetch address generator and the memory-side port of a cache. It holds prefetch requests until the memory side takes them. A demand-access notification opens a round of work. The notification can remove a queued entry for the block that was just accessed. Optionally, it can also squash the most recently queued entries whose ready time is not earlier than the notification time. The generator then streams a list of candidate block addresses, each with a delay. The block examines one candidate per cycle and filters it against three things: the cache contents, the outstanding-miss table and its own entries. A candidate that survives is appended at the tail with a ready time of notification time plus delay. When the queue is full, the oldest entry is evicted to make room.

The cache tag array and the miss-status table are modelled as lookup responses. The responses for the candidate on the candidate port arrive in the same cycle as that candidate. The response for the current head arrives in the same cycle as the head is shown. A configuration bit selects where the cache-presence check happens. With the bit clear, the check is applied when a candidate is pushed. With the bit set, it is applied when the head is about to be handed out, and cached heads are discarded one per cycle. At the end of every accepted notification, the block reports the head's ready time, or zero when the queue is empty. Saturating event counters record the work done.

Top module: `pf_cand_queue`

## Requirements
- R1: A notification with `ntf_uncacheable`=1 is ignored. When `cfg_data_only`=1, a notification with `ntf_ifetch`=1 is also ignored. An ignored notification leaves the queue, the counters and `busy` unchanged and produces no report.
- R2: An accepted notification whose `ntf_addr` equals a queued entry's address removes that entry and increments `cnt_rm_demand`.
- R3: With `cfg_serial_squash`=1, an accepted notification discards entries from the tail, one per cycle, while the tail's ready time is greater than or equal to `ntf_time`. It stops at the first entry that is strictly older. Each discarded entry increments `cnt_squashed`.
- R4: Every candidate received increments `cnt_ident`. A candidate with `cand_in_miss`=1 is dropped. A candidate whose address is already queued is dropped and increments `cnt_buf_hit`.
- R5: With `cfg_check_at_pop`=0, a candidate with `cand_cached`=1 is dropped at push time.
- R6: With `cfg_check_at_pop`=1, cached candidates are queued. A head for which `head_cached`=1 is then discarded without being offered: `head_valid` stays 0 and the next entry becomes the head.
- R7: A surviving candidate that arrives while the queue holds DEPTH entries evicts the head, is appended at the tail, and increments `cnt_rm_full`.
- R8: The ready time of a queued entry is the notification time plus that candidate's `cand_delay`.
- R9: One cycle after the last step of an accepted notification, `rdy_valid` pulses for one cycle. In that cycle `rdy_time` holds the head's ready time, or 0 if the queue is empty.
- R10: Every event counter saturates at all ones.
- R11: `busy` is high from the notification until the report, and `cand_ready` accepts one candidate per cycle. Entries leave in arrival order through `head_valid`/`head_ready`, and each entry taken increments `cnt_issued`.
- R12: After reset the queue is empty, `busy`=0, `head_valid`=0 and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_data_only | input | 1 | Ignore instruction-fetch notifications |
| cfg_serial_squash | input | 1 | Squash younger tail entries on each notification |
| cfg_check_at_pop | input | 1 | 1: cache check at hand-out; 0: at push |
| ntf_valid | input | 1 | Notification strobe, taken when busy is low |
| ntf_addr | input | AW | Demand block address |
| ntf_time | input | TW | Demand time |
| ntf_uncacheable | input | 1 | Demand was uncacheable |
| ntf_ifetch | input | 1 | Demand was an instruction fetch |
| ntf_has_cands | input | 1 | A candidate list follows |
| cand_valid | input | 1 | Candidate present |
| cand_addr | input | AW | Candidate block address |
| cand_delay | input | DW | Candidate delay |
| cand_last | input | 1 | Last candidate of the list |
| cand_cached | input | 1 | Tag lookup: cand_addr is in the cache |
| cand_in_miss | input | 1 | Miss table lookup: cand_addr is outstanding |
| cand_ready | output | 1 | Candidate accepted this cycle |
| busy | output | 1 | Notification in progress |
| head_valid | output | 1 | Head offered to memory side |
| head_ready | input | 1 | Memory side takes the head |
| head_addr | output | AW | Head block address |
| head_time | output | TW | Head ready time |
| head_cached | input | 1 | Tag lookup: head_addr is in the cache |
| rdy_valid | output | 1 | Ready-time report strobe |
| rdy_time | output | TW | Head ready time or 0 |
| cnt_ident | output | CW | Candidates received |
| cnt_issued | output | CW | Entries handed out |
| cnt_rm_demand | output | CW | Entries removed by demand |
| cnt_rm_full | output | CW | Entries evicted on overflow |
| cnt_squashed | output | CW | Entries squashed |
| cnt_buf_hit | output | CW | Candidates already queued |

## Verification
Several properties are checked on every cycle. The occupancy never exceeds the depth. Each hand-out shrinks the queue by one. Overflow appends keep the queue full. An accepted notification raises busy, and an ignored one does not. A report is followed by idle. The counters hold at saturation and change only when incremented. The bench scenarios are what show the rest. Those cover the exact order and ready times of the entries handed out, and the ready-time reports. They also cover which candidates each filter drops, where a squash walk stops, and that a cached head is skipped at hand-out.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef enum logic [1:0] {
        PQ_IDLE   = 2'd0,
        PQ_SQUASH = 2'd1,
        PQ_CAND   = 2'd2,
        PQ_REPORT = 2'd3
    } pfq_state_e;

    localparam int NUM_EVT  = 6;
    localparam int EV_IDENT = 0;
    localparam int EV_ISSUE = 1;
    localparam int EV_DEM   = 2;
    localparam int EV_FULL  = 3;
    localparam int EV_SQ    = 4;
    localparam int EV_BHIT  = 5;
endpackage

// File: rtl/pfq_addr_match.sv
module pfq_addr_match #(
    parameter int DEPTH = 100,
    parameter int AW    = 32,
    localparam int IW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [CNT_W-1:0]         ent_cnt,
    input  logic [AW-1:0]            key,
    output logic                     hit,
    output logic [IW-1:0]            idx
);
    logic [DEPTH-1:0] hv;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hv[i] = (CNT_W'(i) < ent_cnt) && (ent_addr[i] == key);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hv[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pfq_sat_counter.sv
module pfq_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] val
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (inc && (val_q != '1)) val_d = val_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val = val_q;

    a_r10_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (val_q == '1) |=> (val_q == '1));
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(val_q));
endmodule

// File: rtl/pf_cand_queue.sv
module pf_cand_queue
    import pfq_pkg::*;
#(
    parameter int DEPTH = 100,
    parameter int AW    = 32,
    parameter int TW    = 32,
    parameter int DW    = 16,
    parameter int CW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_data_only,
    input  logic          cfg_serial_squash,
    input  logic          cfg_check_at_pop,
    input  logic          ntf_valid,
    input  logic [AW-1:0] ntf_addr,
    input  logic [TW-1:0] ntf_time,
    input  logic          ntf_uncacheable,
    input  logic          ntf_ifetch,
    input  logic          ntf_has_cands,
    input  logic          cand_valid,
    input  logic [AW-1:0] cand_addr,
    input  logic [DW-1:0] cand_delay,
    input  logic          cand_last,
    input  logic          cand_cached,
    input  logic          cand_in_miss,
    output logic          cand_ready,
    output logic          busy,
    output logic          head_valid,
    input  logic          head_ready,
    output logic [AW-1:0] head_addr,
    output logic [TW-1:0] head_time,
    input  logic          head_cached,
    output logic          rdy_valid,
    output logic [TW-1:0] rdy_time,
    output logic [CW-1:0] cnt_ident,
    output logic [CW-1:0] cnt_issued,
    output logic [CW-1:0] cnt_rm_demand,
    output logic [CW-1:0] cnt_rm_full,
    output logic [CW-1:0] cnt_squashed,
    output logic [CW-1:0] cnt_buf_hit
);
    localparam int IW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        pfq_state_e                st;
        logic [CNT_W-1:0]          cnt;
        logic [TW-1:0]             now;
        logic                      more;
        logic [DEPTH-1:0][AW-1:0]  addr;
        logic [DEPTH-1:0][TW-1:0]  tim;
    } regs_t;

    regs_t r_d, r_q;

    logic               ignore_ntf;
    logic               dm_hit, cq_hit;
    logic [IW-1:0]      dm_idx, cq_idx;
    logic               rm_en, app_en;
    logic [IW-1:0]      rm_idx;
    logic [NUM_EVT-1:0] evt;
    logic [IW-1:0]      tail_idx;
    logic               head_present, head_skip;
    logic [CW-1:0]      cnt_vals [NUM_EVT];

    assign ignore_ntf   = ntf_uncacheable || (ntf_ifetch && cfg_data_only);
    assign tail_idx     = IW'(r_q.cnt - 1'b1);
    assign head_present = (r_q.st == PQ_IDLE) && !ntf_valid && (r_q.cnt != '0);
    assign head_skip    = head_present && cfg_check_at_pop && head_cached;

    pfq_addr_match #(.DEPTH(DEPTH), .AW(AW)) u_dm_match (
        .ent_addr (r_q.addr),
        .ent_cnt  (r_q.cnt),
        .key      (ntf_addr),
        .hit      (dm_hit),
        .idx      (dm_idx)
    );

    pfq_addr_match #(.DEPTH(DEPTH), .AW(AW)) u_cq_match (
        .ent_addr (r_q.addr),
        .ent_cnt  (r_q.cnt),
        .key      (cand_addr),
        .hit      (cq_hit),
        .idx      (cq_idx)
    );

    always_comb begin
        r_d    = r_q;
        rm_en  = 1'b0;
        rm_idx = '0;
        app_en = 1'b0;
        evt    = '0;

        unique case (r_q.st)
            PQ_IDLE: begin
                if (ntf_valid) begin
                    if (!ignore_ntf) begin
                        r_d.now  = ntf_time;
                        r_d.more = ntf_has_cands;
                        if (dm_hit) begin
                            rm_en           = 1'b1;
                            rm_idx          = dm_idx;
                            evt[EV_DEM]     = 1'b1;
                        end
                        if (cfg_serial_squash) r_d.st = PQ_SQUASH;
                        else if (ntf_has_cands) r_d.st = PQ_CAND;
                        else                    r_d.st = PQ_REPORT;
                    end
                end else if (head_skip) begin
                    rm_en = 1'b1;
                end else if (head_present && head_ready) begin
                    rm_en         = 1'b1;
                    evt[EV_ISSUE] = 1'b1;
                end
            end
            PQ_SQUASH: begin
                if ((r_q.cnt != '0) && (r_q.tim[tail_idx] >= r_q.now)) begin
                    r_d.cnt    = r_q.cnt - 1'b1;
                    evt[EV_SQ] = 1'b1;
                end else begin
                    r_d.st = r_q.more ? PQ_CAND : PQ_REPORT;
                end
            end
            PQ_CAND: begin
                if (cand_valid) begin
                    evt[EV_IDENT] = 1'b1;
                    if (!cfg_check_at_pop && cand_cached) begin
                        app_en = 1'b0;
                    end else if (cand_in_miss) begin
                        app_en = 1'b0;
                    end else if (cq_hit) begin
                        evt[EV_BHIT] = 1'b1;
                    end else begin
                        app_en = 1'b1;
                        if (r_q.cnt == CNT_W'(DEPTH)) begin
                            rm_en        = 1'b1;
                            evt[EV_FULL] = 1'b1;
                        end
                    end
                    if (cand_last) r_d.st = PQ_REPORT;
                end
            end
            PQ_REPORT: r_d.st = PQ_IDLE;
            default:   r_d.st = PQ_IDLE;
        endcase

        if (rm_en) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IW'(i) >= rm_idx) begin
                    r_d.addr[i] = r_q.addr[i+1];
                    r_d.tim[i]  = r_q.tim[i+1];
                end
            end
            r_d.cnt = r_q.cnt - 1'b1;
        end

        if (app_en) begin
            r_d.addr[IW'(r_d.cnt)] = cand_addr;
            r_d.tim[IW'(r_d.cnt)]  = r_q.now + TW'(cand_delay);
            r_d.cnt                = r_d.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= PQ_IDLE;
            r_q.cnt  <= '0;
            r_q.now  <= '0;
            r_q.more <= 1'b0;
            r_q.addr <= '0;
            r_q.tim  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        pfq_sat_counter #(.W(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (evt[e]),
            .val   (cnt_vals[e])
        );
    end

    assign cnt_ident     = cnt_vals[EV_IDENT];
    assign cnt_issued    = cnt_vals[EV_ISSUE];
    assign cnt_rm_demand = cnt_vals[EV_DEM];
    assign cnt_rm_full   = cnt_vals[EV_FULL];
    assign cnt_squashed  = cnt_vals[EV_SQ];
    assign cnt_buf_hit   = cnt_vals[EV_BHIT];

    assign cand_ready = (r_q.st == PQ_CAND);
    assign busy       = (r_q.st != PQ_IDLE);
    assign head_valid = head_present && !(cfg_check_at_pop && head_cached);
    assign head_addr  = r_q.addr[0];
    assign head_time  = r_q.tim[0];
    assign rdy_valid  = (r_q.st == PQ_REPORT);
    assign rdy_time   = (r_q.cnt != '0) ? r_q.tim[0] : '0;

    a_r12_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CNT_W'(DEPTH));
    a_r11_take_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && head_ready) |=> (r_q.cnt == $past(r_q.cnt) - 1'b1));
    a_r11_busy_after_ntf: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ntf_valid && !ntf_uncacheable && !(ntf_ifetch && cfg_data_only)) |=> busy);
    a_r1_ignored_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ntf_valid && ntf_uncacheable) |=> !busy);
    a_r9_report_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_valid |=> !busy);
    a_r7_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_ready && cand_valid && (r_q.cnt == CNT_W'(DEPTH))) |=> (r_q.cnt == CNT_W'(DEPTH)));
endmodule

// File: tb/pf_cand_queue_tb.sv
module pf_cand_queue_tb;
    localparam int DEPTH = 4;
    localparam int AW = 32, TW = 32, DW = 16, CW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_data_only = 1'b1, cfg_serial_squash = 1'b0, cfg_check_at_pop = 1'b0;
    logic ntf_valid = 1'b0, ntf_uncacheable = 1'b0, ntf_ifetch = 1'b0, ntf_has_cands = 1'b0;
    logic [AW-1:0] ntf_addr = '0;
    logic [TW-1:0] ntf_time = '0;
    logic cand_valid = 1'b0, cand_last = 1'b0, cand_cached, cand_in_miss, cand_ready, busy;
    logic [AW-1:0] cand_addr = '0;
    logic [DW-1:0] cand_delay = '0;
    logic head_valid, head_ready = 1'b0, head_cached, rdy_valid;
    logic [AW-1:0] head_addr;
    logic [TW-1:0] head_time, rdy_time;
    logic [CW-1:0] cnt_ident, cnt_issued, cnt_rm_demand, cnt_rm_full, cnt_squashed, cnt_buf_hit;

    int vectors = 0, miscompares = 0;
    bit finished = 1'b0;
    logic [31:0] exp_a[$];
    logic [31:0] exp_t[$];

    always #4 clk = ~clk;

    // cache model: block 0x240 is resident, block 0x1c0 has an outstanding miss
    assign cand_cached  = (cand_addr == 32'h240);
    assign cand_in_miss = (cand_addr == 32'h1c0);
    assign head_cached  = (head_addr == 32'h240);

    pf_cand_queue #(.DEPTH(DEPTH), .AW(AW), .TW(TW), .DW(DW), .CW(CW)) u_dut (
        .clk, .rst_n, .cfg_data_only, .cfg_serial_squash, .cfg_check_at_pop,
        .ntf_valid, .ntf_addr, .ntf_time, .ntf_uncacheable, .ntf_ifetch, .ntf_has_cands,
        .cand_valid, .cand_addr, .cand_delay, .cand_last, .cand_cached, .cand_in_miss,
        .cand_ready, .busy, .head_valid, .head_ready, .head_addr, .head_time, .head_cached,
        .rdy_valid, .rdy_time, .cnt_ident, .cnt_issued, .cnt_rm_demand, .cnt_rm_full,
        .cnt_squashed, .cnt_buf_hit
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_item(logic [31:0] a, logic [31:0] t);
        exp_a.push_back(a);
        exp_t.push_back(t);
    endtask

    // monitor: compares every hand-out against the scoreboard
    always @(negedge clk) begin
        if (rst_n && head_valid && head_ready) begin
            vectors++;
            if (exp_a.size() == 0) begin
                miscompares++;
                $display("FAIL R11 unexpected hand-out actual=%h expected=none", head_addr);
            end else begin
                logic [31:0] ea, et;
                ea = exp_a.pop_front();
                et = exp_t.pop_front();
                if (head_addr !== ea || head_time !== et) begin
                    miscompares++;
                    $display("FAIL R11/R8 hand-out actual=%h@%0d expected=%h@%0d",
                             head_addr, head_time, ea, et);
                end
            end
        end
    end

    task automatic notify(logic [31:0] a, logic [31:0] t, logic unc, logic ifc, logic hasc);
        @(posedge clk); #1;
        ntf_valid = 1'b1; ntf_addr = a; ntf_time = t;
        ntf_uncacheable = unc; ntf_ifetch = ifc; ntf_has_cands = hasc;
        @(posedge clk); #1;
        ntf_valid = 1'b0; ntf_uncacheable = 1'b0; ntf_ifetch = 1'b0;
    endtask

    task automatic cand(logic [31:0] a, logic [15:0] d, logic last);
        cand_valid = 1'b1; cand_addr = a; cand_delay = d; cand_last = last;
        do @(negedge clk); while (!cand_ready);
        @(posedge clk); #1;
        cand_valid = 1'b0; cand_last = 1'b0;
    endtask

    task automatic wait_report(string tag, logic [31:0] exp);
        int n = 0;
        do begin @(negedge clk); n++; end while (!rdy_valid && n < 50);
        chk(tag, rdy_valid ? rdy_time : 32'hdead_beef, exp);
    endtask

    task automatic drain(int n);
        @(posedge clk); #1 head_ready = 1'b1;
        repeat (n) @(posedge clk);
        #1 head_ready = 1'b0;
        @(negedge clk);
        chk("R11 scoreboard empty after drain", exp_a.size(), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12 busy", busy, 0);
        chk("R12 head_valid", head_valid, 0);
        chk("R12 cnt_ident", cnt_ident, 0);
        chk("R12 cnt_issued", cnt_issued, 0);

        // R8/R9: basic enqueue and report
        notify(32'h100, 10, 0, 0, 1);
        @(negedge clk);
        chk("R11 busy during list", busy, 1);
        @(posedge clk); #1;
        cand(32'h140, 5, 0);
        cand(32'h180, 7, 1);
        wait_report("R8 R9 head ready time", 15);

        // R1: ignored notifications (uncacheable, ifetch in data-only mode)
        notify(32'h140, 20, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk("R1 no report after uncacheable", rdy_valid | busy, 0);
        notify(32'h140, 20, 0, 1, 0);
        repeat (3) @(negedge clk);
        chk("R1 no report after ifetch", rdy_valid | busy, 0);
        chk("R1 demand counter unchanged", cnt_rm_demand, 0);

        // R2: demand hit removes the queued entry
        notify(32'h140, 20, 0, 0, 0);
        wait_report("R2 report after demand removal", 17);
        chk("R2 cnt_rm_demand", cnt_rm_demand, 1);

        // R4/R5: filters
        notify(32'h200, 30, 0, 0, 1);
        cand(32'h180, 1, 0);
        cand(32'h1c0, 2, 0);
        cand(32'h240, 3, 0);
        cand(32'h280, 4, 1);
        wait_report("R4 R5 report after filtered list", 17);
        chk("R4 cnt_buf_hit", cnt_buf_hit, 1);

        // R7/R10: overflow and saturation
        notify(32'h300, 40, 0, 0, 1);
        cand(32'h340, 1, 0);
        cand(32'h380, 2, 0);
        cand(32'h3c0, 3, 1);
        wait_report("R7 head after eviction", 34);
        chk("R7 cnt_rm_full", cnt_rm_full, 1);
        chk("R10 cnt_ident saturated", cnt_ident, 7);
        expect_item(32'h280, 34);
        expect_item(32'h340, 41);
        expect_item(32'h380, 42);
        expect_item(32'h3c0, 43);
        drain(8);
        chk("R11 cnt_issued", cnt_issued, 4);

        // R3: serial squash, partial walk
        cfg_serial_squash = 1'b1;
        notify(32'h400, 50, 0, 0, 1);
        cand(32'h500, 5, 0);
        cand(32'h540, 20, 0);
        cand(32'h580, 10, 1);
        wait_report("R3 report before squash", 55);
        notify(32'h600, 58, 0, 0, 0);
        wait_report("R3 report after squash", 55);
        chk("R3 cnt_squashed", cnt_squashed, 2);
        expect_item(32'h500, 55);
        drain(4);
        notify(32'h610, 70, 0, 0, 0);
        wait_report("R9 empty queue reports zero", 0);

        // R6: cache check at hand-out
        cfg_serial_squash = 1'b0;
        cfg_check_at_pop = 1'b1;
        notify(32'h700, 80, 0, 0, 1);
        cand(32'h240, 1, 0);
        cand(32'h740, 2, 1);
        wait_report("R6 cached candidate queued", 81);
        expect_item(32'h740, 82);
        drain(6);
        chk("R6 cnt_issued", cnt_issued, 6);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule